// File: doc/BRIEF.md
# Configurable Look-Up Logic Cell

This block is one programmable logic element. Its logic function is not built from fixed gates but held as data: a table with one stored bit for every combination of its N logic inputs. The inputs select one stored bit, and that bit is the combinational result. Because every stored bit can be set freely, the cell can compute any function of its N inputs.

A D flip-flop follows the table. It has a clock enable and a synchronous clear. A two-bit mode value chooses what the cell presents. In combinational mode it drives the table bit. In registered mode it drives the flip-flop. In dual mode it drives the table bit on the main pin and the flip-flop on a second pin.

The table bits and the mode bits are written through a one-bit serial load port. Loading new bits changes the function without any change to the ports. While a load is in progress, the cell is held quiet.

Top module: `lut_cell`

## Requirements
- R1: The load chain is 2^N+2 bits long. Each cycle with `cfg_en` high shifts in one bit. The first 2^N bits are table entries, sent for address 0 first and address 2^N-1 last. The last two bits are the mode, sent most significant bit first. The table address is `lin` read as an unsigned number, with `lin[N-1]` (the first input) as the most significant bit.
- R2: In mode 2'b00 (combinational), `y_main` equals the table entry at the address formed by `lin` in the same cycle, and `y_reg` is 0.
- R3: When `ce` is high and `srst` and `cfg_en` are low, the flip-flop captures the table output on the rising clock edge. In mode 2'b01 (registered), `y_main` shows the flip-flop value and `y_reg` is 0.
- R4: When `ce` is low, and `srst` and `cfg_en` are also low, the flip-flop keeps its value.
- R5: `srst` high clears the flip-flop on the next rising edge, even when `ce` is high.
- R6: In mode 2'b10 (dual), `y_main` is the combinational table output and `y_reg` is the flip-flop value.
- R7: While `cfg_en` is high, `y_main` and `y_reg` are 0 and the flip-flop is cleared on each edge.
- R8: A newly loaded function, and its mode, take effect in the first cycle after `cfg_en` falls.
- R9: After `rst_n` is asserted, the table and mode are all zero, so the cell is in combinational mode with a constant-0 function. The flip-flop is 0 and both outputs are 0.
- R10: Mode 2'b11 behaves like combinational mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Serial load active; shifts one bit per cycle |
| cfg_din | input | 1 | Serial load data |
| ce | input | 1 | Flip-flop clock enable |
| srst | input | 1 | Flip-flop synchronous clear |
| lin | input | N | Logic inputs; the table address |
| y_main | output | 1 | Main cell output |
| y_reg | output | 1 | Registered output in dual mode, else 0 |

## Verification
The assertions assume that `ce`, `srst`, `lin` and `cfg_en` change only away from the rising edge and stay stable across it. Under that assumption, the captured value is the table bit that was visible just before the edge. They also assume that a load runs for exactly 2^N+2 cycles with `cfg_en` high. A shorter or longer burst leaves the table and mode misaligned in ways the checks cannot tell apart.

The stimulus drives every input a short time after the rising edge. Each load is issued as one unbroken burst of exactly the chain length. Flip-flop control changes occur only between whole load bursts.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

    typedef enum logic [1:0] {
        MODE_COMB = 2'b00,
        MODE_REG  = 2'b01,
        MODE_DUAL = 2'b10,
        MODE_SPARE = 2'b11
    } cell_mode_e;

    typedef struct packed {
        logic q;
    } ff_state_t;

endpackage

// File: rtl/lut_cfg_chain.sv
module lut_cfg_chain #(
    parameter int N = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_en,
    input  logic                cfg_din,
    output logic [(1<<N)-1:0]   table_bits,
    output logic [1:0]          mode_bits
);
    localparam int ENTRIES = 1 << N;
    localparam int CHAIN   = ENTRIES + 2;

    typedef struct packed {
        logic [CHAIN-1:0] sr;
    } chain_state_t;

    chain_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_en) begin
            st_d.sr = {st_q.sr[CHAIN-2:0], cfg_din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // The first table bit shifted in ends up at the top of the chain.
    for (genvar a = 0; a < ENTRIES; a++) begin : g_map
        assign table_bits[a] = st_q.sr[CHAIN-1-a];
    end

    assign mode_bits = st_q.sr[1:0];
endmodule

// File: rtl/lut_read.sv
module lut_read #(
    parameter int N = 4
) (
    input  logic [(1<<N)-1:0] table_bits,
    input  logic [N-1:0]      addr,
    output logic              bit_out
);
    localparam int ENTRIES = 1 << N;

    // Binary mux tree, one level per address bit.
    logic [2*ENTRIES-2:0] node;

    for (genvar a = 0; a < ENTRIES; a++) begin : g_leaf
        assign node[ENTRIES-1+a] = table_bits[a];
    end

    for (genvar lvl = 0; lvl < N; lvl++) begin : g_lvl
        localparam int FIRST = (1 << lvl) - 1;
        localparam int COUNT = 1 << lvl;
        for (genvar k = 0; k < COUNT; k++) begin : g_node
            assign node[FIRST+k] = addr[N-1-lvl] ? node[2*(FIRST+k)+2]
                                                 : node[2*(FIRST+k)+1];
        end
    end

    assign bit_out = node[0];
endmodule

// File: rtl/lut_cell_ff.sv
module lut_cell_ff
    import lut_cell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_clear,
    input  logic ce,
    input  logic srst,
    input  logic d,
    output logic q
);
    ff_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold_clear || srst) begin
            st_d.q = 1'b0;
        end else if (ce) begin
            st_d.q = d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.q;
endmodule

// File: rtl/lut_cell.sv
module lut_cell
    import lut_cell_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_en,
    input  logic         cfg_din,
    input  logic         ce,
    input  logic         srst,
    input  logic [N-1:0] lin,
    output logic         y_main,
    output logic         y_reg
);
    localparam int ENTRIES = 1 << N;

    logic [ENTRIES-1:0] table_bits;
    logic [1:0]         mode_q;
    logic               lut_bit;
    logic               ff_q;

    initial begin
        if (N < 4 || N > 6) $error("lut_cell: N must be 4 to 6");
    end

    lut_cfg_chain #(.N(N)) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_en     (cfg_en),
        .cfg_din    (cfg_din),
        .table_bits (table_bits),
        .mode_bits  (mode_q)
    );

    lut_read #(.N(N)) u_read (
        .table_bits (table_bits),
        .addr       (lin),
        .bit_out    (lut_bit)
    );

    lut_cell_ff u_ff (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_clear (cfg_en),
        .ce         (ce),
        .srst       (srst),
        .d          (lut_bit),
        .q          (ff_q)
    );

    always_comb begin
        y_main = 1'b0;
        y_reg  = 1'b0;
        if (!cfg_en) begin
            unique case (cell_mode_e'(mode_q))
                MODE_REG:  y_main = ff_q;
                MODE_DUAL: begin
                    y_main = lut_bit;
                    y_reg  = ff_q;
                end
                default:   y_main = lut_bit;
            endcase
        end
    end
endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_en,
    input logic       ce,
    input logic       srst,
    input logic       lut_bit,
    input logic       ff_q,
    input logic [1:0] mode_q,
    input logic       y_main,
    input logic       y_reg
);
    assert_cfg_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> (!y_main && !y_reg));

    assert_cfg_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> !ff_q);

    assert_srst_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> !ff_q);

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !srst && !cfg_en) |=> $stable(ff_q));

    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !srst && !cfg_en) |=> (ff_q == $past(lut_bit)));

    assert_reg_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && mode_q != 2'b10) |-> !y_reg);

    assert_dual_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && mode_q == 2'b10) |-> (y_reg == ff_q && y_main == lut_bit));
endmodule

bind lut_cell lut_cell_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .ce      (ce),
    .srst    (srst),
    .lut_bit (lut_bit),
    .ff_q    (ff_q),
    .mode_q  (mode_q),
    .y_main  (y_main),
    .y_reg   (y_reg)
);

// File: tb/test_lut_cell.sv
module test_lut_cell;
    localparam int N = 4;
    localparam int ENTRIES = 1 << N;

    typedef struct {
        logic  e_main;
        logic  e_reg;
        string tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_en = 1'b0;
    logic         cfg_din = 1'b0;
    logic         ce = 1'b0;
    logic         srst = 1'b0;
    logic [N-1:0] lin = '0;
    logic         y_main;
    logic         y_reg;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    exp_t q[$];
    logic [ENTRIES-1:0] tbl_m = '0;
    logic [1:0]         mode_m = 2'b00;
    logic               ff_m = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    lut_cell #(.N(N)) i_lut_cell (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .ce(ce), .srst(srst), .lin(lin), .y_main(y_main), .y_reg(y_reg)
    );

    task automatic check(input logic am, input logic ar, input logic em,
                         input logic er, input string tag);
        checks++;
        if (am !== em || ar !== er) begin
            failures++;
            $display("FAIL %s: y_main=%b y_reg=%b expected y_main=%b y_reg=%b",
                     tag, am, ar, em, er);
        end
    endtask

    // Driver: one cycle of normal operation, prediction pushed to scoreboard.
    task automatic step(input logic [N-1:0] l, input logic c, input logic s,
                        input string tag);
        exp_t it;
        logic comb;
        @(posedge clk); #2;
        cfg_en = 1'b0; lin = l; ce = c; srst = s;
        comb = tbl_m[l];
        if (s) ff_m = 1'b0;
        else if (c) ff_m = comb;
        case (mode_m)
            2'b01:   begin it.e_main = ff_m; it.e_reg = 1'b0; end
            2'b10:   begin it.e_main = comb; it.e_reg = ff_m; end
            default: begin it.e_main = comb; it.e_reg = 1'b0; end
        endcase
        it.tag = tag;
        q.push_back(it);
    endtask

    // Serial load: table address 0 first, then mode MSB first (R1).
    task automatic load(input logic [ENTRIES-1:0] t, input logic [1:0] m);
        exp_t it;
        for (int i = 0; i < ENTRIES + 2; i++) begin
            @(posedge clk); #2;
            cfg_en = 1'b1;
            cfg_din = (i < ENTRIES) ? t[i] : m[ENTRIES + 1 - i];
            ff_m = 1'b0;
            it.e_main = 1'b0; it.e_reg = 1'b0; it.tag = "R7 outputs quiet during load";
            q.push_back(it);
        end
        tbl_m = t;
        mode_m = m;
    endtask

    function automatic logic [ENTRIES-1:0] make_tbl(input int kind);
        logic [ENTRIES-1:0] t;
        for (int a = 0; a < ENTRIES; a++) begin
            logic [N-1:0] ad;
            ad = N'(a);
            case (kind)
                0: t[a] = ad[N-1] ^ ad[N-2];   // XOR of the first two inputs
                1: t[a] = &ad;                 // AND
                2: t[a] = ~|ad;                // NOR
                3: t[a] = 1'b1;                // constant 1
                default: t[a] = (a == 5);      // one-hot at address 5
            endcase
        end
        return t;
    endfunction

    // Monitor: samples 1 ns after the edge, driver moves at 2 ns.
    initial begin
        forever begin
            @(posedge clk); #1;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                check(y_main, y_reg, it.e_main, it.e_reg, it.tag);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R9: reset state
        check(y_main, y_reg, 1'b0, 1'b0, "R9 outputs during reset");
        rst_n = 1'b1;
        for (int a = 0; a < ENTRIES; a++) step(N'(a), 1'b1, 1'b0, "R9 empty table gives 0");

        // R1: address order, one-hot at address 5 (lin=4'b0101)
        load(make_tbl(4), 2'b00);
        for (int a = 0; a < ENTRIES; a++) step(N'(a), 1'b0, 1'b0, "R1 address order");

        // R2: combinational XOR of first two inputs
        load(make_tbl(0), 2'b00);
        for (int a = 0; a < ENTRIES; a++) step(N'(a), 1'b1, 1'b0, "R2 comb XOR");

        // R8: reload with AND, first cycle after load already uses it
        load(make_tbl(1), 2'b00);
        step(4'hF, 1'b0, 1'b0, "R8 new function first cycle");
        step(4'hE, 1'b0, 1'b0, "R8 new function");

        // R3: registered mode
        load(make_tbl(1), 2'b01);
        step(4'hF, 1'b1, 1'b0, "R3 capture 1");
        step(4'h3, 1'b1, 1'b0, "R3 capture 0");
        step(4'hF, 1'b1, 1'b0, "R3 capture 1 again");
        // R4: hold with ce low
        step(4'h0, 1'b0, 1'b0, "R4 hold");
        step(4'h1, 1'b0, 1'b0, "R4 hold");
        // R5: srst beats ce
        step(4'hF, 1'b1, 1'b1, "R5 srst priority");
        step(4'hF, 1'b0, 1'b0, "R5 stays cleared");
        step(4'hF, 1'b1, 1'b0, "R3 capture after clear");

        // R6: dual mode with NOR
        load(make_tbl(2), 2'b10);
        step(4'h0, 1'b1, 1'b0, "R6 dual capture");
        step(4'h4, 1'b0, 1'b0, "R6 dual comb differs from reg");
        step(4'h4, 1'b1, 1'b0, "R6 dual capture 0");
        step(4'h0, 1'b0, 1'b1, "R6 dual srst");
        step(4'h0, 1'b1, 1'b0, "R6 dual capture 1");

        // R7: load clears flip-flop, then R10: mode 11 acts as comb
        load(make_tbl(3), 2'b11);
        for (int a = 0; a < 4; a++) step(N'(a * 5), 1'b1, 1'b0, "R10 spare mode comb");
        load(make_tbl(0), 2'b01);
        step(4'h0, 1'b0, 1'b0, "R7 flip-flop cleared by load");

        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule